// File: doc/BRIEF.md
# Bit- and Nibble-Addressed GPIO Port Controller

This block is the general-purpose I/O controller of a small microcontroller. It serves two groups of pins. The first group is bit-addressed. It has nine bidirectional pins, numbered 0 to 8, which the CPU sets or clears one at a time. It also has two input-only pins, numbered 10 and 11. Any of these pins can be tested on its own, and the test returns the pin's present level. Pin 10 can also act as a stop-request input, and pin 11 can also act as an external interrupt request. A mode register selects either role for each.

The second group has 24 bidirectional pins arranged as six 4-bit ports. A nibble write loads the output latches of one port. A nibble read returns the levels of that port's four pins.

Output-buffer enables and the mode register sit on a narrow memory-mapped register bus, which has a write strobe and a combinational read. Every pin keeps its output value in a latch that is independent of its enable. A synchronous reset, which is also used on entry to stop mode, clears every latch and register, so all pins float.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the following are cleared: all output latches, all output enables and the mode bits. After that edge, `pin_oe`, `r_oe`, `pin_out`, `r_out`, `stop_req`, `irq0_req` and every register readback are 0.
- R2: `bit_op` uses the encoding 0 = none, 1 = set, 2 = clear, 3 = test. A set or clear with `bit_idx` 0..8 changes only bit `bit_idx` of `pin_out`, one cycle later. A set or clear with `bit_idx` 9..15 changes nothing.
- R3: With `bit_op` = 3, `bit_level` returns the level of the addressed pin. For indices 0..8 this is `pin_out[i]` if `pin_oe[i]` is 1, and `pin_in[i]` otherwise. Index 10 returns `ip_in[0]` and index 11 returns `ip_in[1]`, whatever the mode. Indices 9 and 12..15 return 0.
- R4: Registers at 0x2C, 0x2D and 0x2E hold the output enables of pins 0–3, 4–7 and 8. Register bit b controls pin 4k+b, and the write takes effect one cycle later. The enables read back. Bits that have no pin read 0.
- R5: In the mode register at 0x25, bit 2 selects the stop function for pin 10 and bit 3 selects the interrupt function for pin 11. The other bits read 0. `stop_req` equals `ip_in[0]` when bit 2 is set and is 0 otherwise. `irq0_req` equals `ip_in[1]` when bit 3 is set and is 0 otherwise.
- R6: A nibble write (`nib_wr`) with `nib_sel` 0..5 loads `nib_wdata` into `r_out[4*sel+3:4*sel]` one cycle later. With `nib_sel` 6 or 7 the write is ignored.
- R7: A nibble read returns, for each bit j of port `nib_sel`, `r_out` if `r_oe` is 1 for that pin and `r_in` otherwise. `nib_sel` 6 or 7 reads 0.
- R8: Registers at 0x30–0x33 hold the enables of ports 0–3, and 0x36 and 0x37 hold the enables of ports 4 and 5. Bit j of a register enables pin j of its port. These registers read back.
- R9: Register addresses outside {0x25, 0x2C–0x2E, 0x30–0x33, 0x36, 0x37} read 0, and writes to them change no enable.
- R10: An output latch keeps a value written while its pin is disabled. Once the enable is set, the pin drives that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (also used on stop-mode entry) |
| reg_addr | input | 6 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data (combinational) |
| bit_op | input | 2 | Bit command: 0 none, 1 set, 2 clear, 3 test |
| bit_idx | input | 4 | Bit-addressed pin index |
| bit_level | output | 1 | Level of the addressed pin during a test |
| pin_in | input | 9 | External levels of bidirectional pins 0..8 |
| pin_out | output | 9 | Output latches of pins 0..8 |
| pin_oe | output | 9 | Output enables of pins 0..8 |
| ip_in | input | 2 | Levels of input-only pins 10 (bit 0) and 11 (bit 1) |
| stop_req | output | 1 | Stop request routed from pin 10 |
| irq0_req | output | 1 | Interrupt request routed from pin 11 |
| nib_wr | input | 1 | Nibble write strobe |
| nib_sel | input | 3 | Nibble port number |
| nib_wdata | input | 4 | Nibble write data |
| nib_rdata | output | 4 | Nibble read data (pin levels) |
| r_in | input | 24 | External levels of the nibble-port pins |
| r_out | output | 24 | Output latches of the nibble-port pins |
| r_oe | output | 24 | Output enables of the nibble-port pins |

## Verification
A sequence of bit commands alternates sets and clears across both edge pins, 0 and 8, and the middle pins. Out-of-range indices are scattered through it, so the sequence shows whether a command reaches exactly one latch or leaks into others. Test reads are then taken with pins driven and undriven, and with external levels that disagree with the latch, which shows whether the returned level comes from the latch or from the pad. Nibble reads use enable patterns that split a port in half, and a latch is loaded while its port is disabled, so per-bit enable selection and latch retention are both seen. Mode-bit and input-level combinations show that the peripheral routing and the raw pin test stay separate.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BIDIR_PINS = 9;
    localparam int IDX_W      = 4;
    localparam int NIB_W      = 4;
    localparam int NIB_PORTS  = 6;
    localparam int SEL_W      = 3;
    localparam int R_PINS     = NIB_W * NIB_PORTS;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 4;
    localparam int STOP_IDX   = 10;
    localparam int IRQ_IDX    = 11;
    localparam int LEVEL_N    = 1 << IDX_W;

    localparam logic [ADDR_W-1:0] A_MODE    = 6'h25;
    localparam logic [ADDR_W-1:0] A_DOE_LO  = 6'h2C;
    localparam logic [ADDR_W-1:0] A_DOE_HI  = 6'h2E;
    localparam logic [ADDR_W-1:0] A_ROE0_LO = 6'h30;
    localparam logic [ADDR_W-1:0] A_ROE0_HI = 6'h33;
    localparam logic [ADDR_W-1:0] A_ROE1_LO = 6'h36;
    localparam logic [ADDR_W-1:0] A_ROE1_HI = 6'h37;
    localparam int ROE0_COUNT = 4;

    localparam int MODE_STOP_BIT = 2;
    localparam int MODE_IRQ_BIT  = 3;

    typedef enum logic [1:0] {
        BIT_NOP  = 2'd0,
        BIT_SET  = 2'd1,
        BIT_CLR  = 2'd2,
        BIT_TEST = 2'd3
    } bit_op_e;

    typedef struct packed {
        logic             is_mode;
        logic             is_doe;
        logic             is_roe;
        logic [SEL_W-1:0] sel;
    } reg_dec_t;

    function automatic reg_dec_t reg_decode(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d = '0;
        if (a == A_MODE) begin
            d.is_mode = 1'b1;
        end else if (a >= A_DOE_LO && a <= A_DOE_HI) begin
            d.is_doe = 1'b1;
            d.sel    = SEL_W'(a - A_DOE_LO);
        end else if (a >= A_ROE0_LO && a <= A_ROE0_HI) begin
            d.is_roe = 1'b1;
            d.sel    = SEL_W'(a - A_ROE0_LO);
        end else if (a >= A_ROE1_LO && a <= A_ROE1_HI) begin
            d.is_roe = 1'b1;
            d.sel    = SEL_W'(a - A_ROE1_LO) + SEL_W'(ROE0_COUNT);
        end
        return d;
    endfunction

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d = reg_decode(a);
        return d.is_mode | d.is_doe | d.is_roe;
    endfunction

endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_pkg::*;
#(
    parameter int N_BIDIR = BIDIR_PINS,
    parameter int N_RPIN  = R_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_BIDIR-1:0] d_oe,
    output logic [N_RPIN-1:0]  r_oe,
    output logic              mode_stop,
    output logic              mode_irq
);

    reg_dec_t dec;

    always_comb dec = reg_decode(addr);

    // Enables kept per pin; register k, bit b maps to pin k*DATA_W+b.
    always_ff @(posedge clk) begin
        if (rst) begin
            d_oe      <= '0;
            r_oe      <= '0;
            mode_stop <= 1'b0;
            mode_irq  <= 1'b0;
        end else if (wr) begin
            for (int i = 0; i < N_BIDIR; i++) begin
                if (dec.is_doe && int'(dec.sel) == i / DATA_W)
                    d_oe[i] <= wdata[i % DATA_W];
            end
            for (int i = 0; i < N_RPIN; i++) begin
                if (dec.is_roe && int'(dec.sel) == i / DATA_W)
                    r_oe[i] <= wdata[i % DATA_W];
            end
            if (dec.is_mode) begin
                mode_stop <= wdata[MODE_STOP_BIT];
                mode_irq  <= wdata[MODE_IRQ_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (dec.is_mode) begin
            rdata[MODE_STOP_BIT] = mode_stop;
            rdata[MODE_IRQ_BIT]  = mode_irq;
        end
        for (int i = 0; i < N_BIDIR; i++) begin
            if (dec.is_doe && int'(dec.sel) == i / DATA_W)
                rdata[i % DATA_W] = d_oe[i];
        end
        for (int i = 0; i < N_RPIN; i++) begin
            if (dec.is_roe && int'(dec.sel) == i / DATA_W)
                rdata[i % DATA_W] = r_oe[i];
        end
    end

endmodule

// File: rtl/gpio_bitport.sv
module gpio_bitport
    import gpio_pkg::*;
#(
    parameter int N_BIDIR = BIDIR_PINS
) (
    input  logic               clk,
    input  logic               rst,
    input  bit_op_e            op,
    input  logic [IDX_W-1:0]   idx,
    input  logic [N_BIDIR-1:0] pin_in,
    input  logic [1:0]         ip_in,
    input  logic [N_BIDIR-1:0] oe,
    output logic [N_BIDIR-1:0] latch,
    output logic               level
);

    logic [LEVEL_N-1:0] pin_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch <= '0;
        end else begin
            for (int i = 0; i < N_BIDIR; i++) begin
                if (int'(idx) == i) begin
                    if (op == BIT_SET) latch[i] <= 1'b1;
                    if (op == BIT_CLR) latch[i] <= 1'b0;
                end
            end
        end
    end

    // Level table over the whole index space; absent indices read 0.
    for (genvar g = 0; g < LEVEL_N; g++) begin : g_level
        if (g < N_BIDIR) begin : g_bidir
            assign pin_level[g] = oe[g] ? latch[g] : pin_in[g];
        end else if (g == STOP_IDX) begin : g_stop
            assign pin_level[g] = ip_in[0];
        end else if (g == IRQ_IDX) begin : g_irq
            assign pin_level[g] = ip_in[1];
        end else begin : g_none
            assign pin_level[g] = 1'b0;
        end
    end

    assign level = (op == BIT_TEST) ? pin_level[idx] : 1'b0;

endmodule

// File: rtl/gpio_nibport.sv
module gpio_nibport
    import gpio_pkg::*;
#(
    parameter int N_PORTS = NIB_PORTS,
    parameter int W       = NIB_W,
    localparam int N_PIN  = N_PORTS * W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     wdata,
    input  logic [N_PIN-1:0] r_in,
    input  logic [N_PIN-1:0] oe,
    output logic [N_PIN-1:0] latch,
    output logic [W-1:0]     rdata
);

    logic [N_PIN-1:0] level;
    logic [W-1:0]     port_level [N_PORTS];

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst)
                latch[p*W +: W] <= '0;
            else if (wr && int'(sel) == p)
                latch[p*W +: W] <= wdata;
        end
        assign level[p*W +: W] = (oe[p*W +: W] & latch[p*W +: W]) |
                                 (~oe[p*W +: W] & r_in[p*W +: W]);
        assign port_level[p]   = level[p*W +: W];
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (int'(sel) == p) rdata = port_level[p];
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [1:0]            bit_op,
    input  logic [IDX_W-1:0]      bit_idx,
    output logic                  bit_level,
    input  logic [BIDIR_PINS-1:0] pin_in,
    output logic [BIDIR_PINS-1:0] pin_out,
    output logic [BIDIR_PINS-1:0] pin_oe,
    input  logic [1:0]            ip_in,
    output logic                  stop_req,
    output logic                  irq0_req,
    input  logic                  nib_wr,
    input  logic [SEL_W-1:0]      nib_sel,
    input  logic [NIB_W-1:0]      nib_wdata,
    output logic [NIB_W-1:0]      nib_rdata,
    input  logic [R_PINS-1:0]     r_in,
    output logic [R_PINS-1:0]     r_out,
    output logic [R_PINS-1:0]     r_oe
);

    logic mode_stop;
    logic mode_irq;

    gpio_ctrl_regs #(.N_BIDIR(BIDIR_PINS), .N_RPIN(R_PINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .d_oe      (pin_oe),
        .r_oe      (r_oe),
        .mode_stop (mode_stop),
        .mode_irq  (mode_irq)
    );

    gpio_bitport #(.N_BIDIR(BIDIR_PINS)) u_bits (
        .clk    (clk),
        .rst    (rst),
        .op     (bit_op_e'(bit_op)),
        .idx    (bit_idx),
        .pin_in (pin_in),
        .ip_in  (ip_in),
        .oe     (pin_oe),
        .latch  (pin_out),
        .level  (bit_level)
    );

    gpio_nibport #(.N_PORTS(NIB_PORTS), .W(NIB_W)) u_nibs (
        .clk   (clk),
        .rst   (rst),
        .wr    (nib_wr),
        .sel   (nib_sel),
        .wdata (nib_wdata),
        .r_in  (r_in),
        .oe    (r_oe),
        .latch (r_out),
        .rdata (nib_rdata)
    );

    // Peripheral routing leaves the raw pin test untouched.
    assign stop_req = mode_stop & ip_in[0];
    assign irq0_req = mode_irq  & ip_in[1];

endmodule

// File: rtl/gpio_port_ctrl_sva.sv
module gpio_port_ctrl_sva
    import gpio_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  reg_wr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic [1:0]            bit_op,
    input logic [IDX_W-1:0]      bit_idx,
    input logic [BIDIR_PINS-1:0] pin_out,
    input logic [BIDIR_PINS-1:0] pin_oe,
    input logic [1:0]            ip_in,
    input logic                  stop_req,
    input logic                  irq0_req,
    input logic                  nib_wr,
    input logic [SEL_W-1:0]      nib_sel,
    input logic [NIB_W-1:0]      nib_wdata,
    input logic [NIB_W-1:0]      nib_rdata,
    input logic [R_PINS-1:0]     r_out,
    input logic [R_PINS-1:0]     r_oe
);

    assert_reset_floats_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && r_oe == '0 && pin_out == '0 && r_out == '0));

    assert_bit_set_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_op == BIT_SET && bit_idx < IDX_W'(BIDIR_PINS)) |=> pin_out[$past(bit_idx)]);

    assert_bit_clr_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_op == BIT_CLR && bit_idx < IDX_W'(BIDIR_PINS)) |=> !pin_out[$past(bit_idx)]);

    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_op != BIT_SET && bit_op != BIT_CLR) |=> $stable(pin_out));

    assert_doe_write_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_DOE_LO) |=> pin_oe[3:0] == $past(reg_wdata));

    assert_stop_route_R5: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> ip_in[0]);

    assert_irq_route_R5: assert property (@(posedge clk) disable iff (rst)
        irq0_req |-> ip_in[1]);

    assert_nib_write_R6: assert property (@(posedge clk) disable iff (rst)
        (nib_wr && nib_sel < SEL_W'(NIB_PORTS)) |=>
            r_out[{$past(nib_sel), 2'b00} +: NIB_W] == $past(nib_wdata));

    assert_nib_bad_sel_R7: assert property (@(posedge clk) disable iff (rst)
        (nib_sel >= SEL_W'(NIB_PORTS)) |-> nib_rdata == '0);

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !is_mapped(reg_addr)) |=> ($stable(pin_oe) && $stable(r_oe)));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .bit_op    (bit_op),
    .bit_idx   (bit_idx),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .ip_in     (ip_in),
    .stop_req  (stop_req),
    .irq0_req  (irq0_req),
    .nib_wr    (nib_wr),
    .nib_sel   (nib_sel),
    .nib_wdata (nib_wdata),
    .nib_rdata (nib_rdata),
    .r_out     (r_out),
    .r_oe      (r_oe)
);

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_wdata = '0;
    logic [3:0]  reg_rdata;
    logic [1:0]  bit_op = 2'd0;
    logic [3:0]  bit_idx = '0;
    logic        bit_level;
    logic [8:0]  pin_in = '0;
    logic [8:0]  pin_out;
    logic [8:0]  pin_oe;
    logic [1:0]  ip_in = '0;
    logic        stop_req;
    logic        irq0_req;
    logic        nib_wr = 1'b0;
    logic [2:0]  nib_sel = '0;
    logic [3:0]  nib_wdata = '0;
    logic [3:0]  nib_rdata;
    logic [23:0] r_in = '0;
    logic [23:0] r_out;
    logic [23:0] r_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (.*);

    // Vector: op[14:13] (1 set, 2 clear, 0 none), idx[12:9], expected pin_out[8:0].
    localparam logic [14:0] BIT_VEC [12] = '{
        {2'd1, 4'd0,  9'h001},
        {2'd1, 4'd8,  9'h101},
        {2'd1, 4'd9,  9'h101},
        {2'd1, 4'd4,  9'h111},
        {2'd2, 4'd0,  9'h110},
        {2'd1, 4'd15, 9'h110},
        {2'd2, 4'd8,  9'h010},
        {2'd1, 4'd3,  9'h018},
        {2'd2, 4'd12, 9'h018},
        {2'd1, 4'd7,  9'h098},
        {2'd2, 4'd4,  9'h088},
        {2'd0, 4'd2,  9'h088}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [3:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [3:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic bit_cmd(input logic [1:0] op, input logic [3:0] idx);
        @(negedge clk);
        bit_op = op; bit_idx = idx;
        @(negedge clk);
        bit_op = 2'd0;
    endtask

    task automatic bit_test(input logic [3:0] idx, output logic lvl);
        bit_op = 2'd3; bit_idx = idx;
        #1;
        lvl = bit_level;
        bit_op = 2'd0;
    endtask

    task automatic nib_write(input logic [2:0] s, input logic [3:0] d);
        @(negedge clk);
        nib_sel = s; nib_wdata = d; nib_wr = 1'b1;
        @(negedge clk);
        nib_wr = 1'b0;
    endtask

    task automatic nib_read(input logic [2:0] s, output logic [3:0] d);
        nib_sel = s;
        #1;
        d = nib_rdata;
    endtask

    task automatic check_reset_state();
        logic [3:0] rd;
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 r_oe", 32'(r_oe), 0);
        chk("R1 pin_out", 32'(pin_out), 0);
        chk("R1 r_out", 32'(r_out), 0);
        chk("R1 stop_req", 32'(stop_req), 0);
        chk("R1 irq0_req", 32'(irq0_req), 0);
        reg_read(6'h2C, rd); chk("R1 read 0x2C", 32'(rd), 0);
        reg_read(6'h25, rd); chk("R1 read 0x25", 32'(rd), 0);
        reg_read(6'h37, rd); chk("R1 read 0x37", 32'(rd), 0);
    endtask

    initial begin
        #(20 * 5000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] rd;
        logic       lv;
        ip_in = 2'b11;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state();

        // R2: table of bit commands.
        for (int k = 0; k < 12; k++) begin
            bit_cmd(BIT_VEC[k][14:13], BIT_VEC[k][12:9]);
            chk($sformatf("R2 vec %0d", k), 32'(pin_out), 32'(BIT_VEC[k][8:0]));
        end

        // R4: bit-port enable registers.
        reg_write(6'h2C, 4'hF);
        reg_write(6'h2D, 4'h5);
        reg_write(6'h2E, 4'hF);
        chk("R4 pin_oe", 32'(pin_oe), 32'h15F);
        reg_read(6'h2E, rd); chk("R4 read 0x2E unused bits", 32'(rd), 32'h1);
        reg_read(6'h2D, rd); chk("R4 read 0x2D", 32'(rd), 32'h5);

        // R3: pin test, latch is 0x088, enabled pins 0-3,4,6,8.
        pin_in = 9'h081; ip_in = 2'b11;
        bit_test(4'd3, lv);  chk("R3 idx3 driven", 32'(lv), 1);
        bit_test(4'd7, lv);  chk("R3 idx7 undriven", 32'(lv), 1);
        bit_test(4'd0, lv);  chk("R3 idx0 driven low", 32'(lv), 0);
        bit_test(4'd9, lv);  chk("R3 idx9 absent", 32'(lv), 0);
        bit_test(4'd10, lv); chk("R3 idx10", 32'(lv), 1);
        bit_test(4'd11, lv); chk("R3 idx11", 32'(lv), 1);
        bit_test(4'd13, lv); chk("R3 idx13 absent", 32'(lv), 0);

        // R5: mode register.
        chk("R5 stop off", 32'(stop_req), 0);
        reg_write(6'h25, 4'hF);
        reg_read(6'h25, rd); chk("R5 read mode", 32'(rd), 32'hC);
        chk("R5 stop on", 32'(stop_req), 1);
        chk("R5 irq on", 32'(irq0_req), 1);
        ip_in = 2'b10; #1;
        chk("R5 stop follows pin", 32'(stop_req), 0);
        bit_test(4'd10, lv); chk("R5 raw test idx10", 32'(lv), 0);
        reg_write(6'h25, 4'h4);
        chk("R5 irq deselected", 32'(irq0_req), 0);
        ip_in = 2'b11; #1;
        chk("R5 stop selected", 32'(stop_req), 1);
        bit_test(4'd11, lv); chk("R5 raw test idx11", 32'(lv), 1);

        // R6: nibble writes.
        nib_write(3'd2, 4'hA);
        chk("R6 port2", 32'(r_out), 32'h000A00);
        nib_write(3'd6, 4'hF);
        chk("R6 sel6 ignored", 32'(r_out), 32'h000A00);
        nib_write(3'd5, 4'h3);
        chk("R6 port5", 32'(r_out), 32'h300A00);

        // R8: nibble enable registers.
        reg_write(6'h32, 4'hC);
        reg_write(6'h37, 4'hF);
        reg_write(6'h36, 4'h1);
        chk("R8 r_oe", 32'(r_oe), 32'hF10C00);
        reg_read(6'h37, rd); chk("R8 read 0x37", 32'(rd), 32'hF);
        reg_read(6'h36, rd); chk("R8 read 0x36", 32'(rd), 32'h1);

        // R7: nibble reads.
        r_in = 24'h0005F0;
        nib_read(3'd2, rd); chk("R7 port2 split", 32'(rd), 32'h9);
        nib_read(3'd1, rd); chk("R7 port1 undriven", 32'(rd), 32'hF);
        nib_read(3'd5, rd); chk("R7 port5 driven", 32'(rd), 32'h3);
        nib_read(3'd6, rd); chk("R7 sel6 zero", 32'(rd), 0);

        // R9: unmapped addresses.
        reg_write(6'h34, 4'hF);
        reg_read(6'h34, rd); chk("R9 read 0x34", 32'(rd), 0);
        chk("R9 r_oe kept", 32'(r_oe), 32'hF10C00);
        reg_write(6'h2F, 4'hF);
        chk("R9 pin_oe kept", 32'(pin_oe), 32'h15F);
        reg_read(6'h26, rd); chk("R9 read 0x26", 32'(rd), 0);

        // R10: latch retained while disabled.
        r_in = 24'h0005F9;
        nib_write(3'd0, 4'h6);
        chk("R10 latch loaded", 32'(r_out[3:0]), 32'h6);
        nib_read(3'd0, rd); chk("R10 disabled reads pad", 32'(rd), 32'h9);
        reg_write(6'h30, 4'hF);
        nib_read(3'd0, rd); chk("R10 enabled drives latch", 32'(rd), 32'h6);

        // R1: reset again clears everything.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule